// File: doc/BRIEF.md
# Immediate call decoder for a dual instruction-set core

This block sits in the execute stage of a core that runs two instruction sets: a wide set whose words are always 32 bits, and a compact set whose long forms occupy two 16-bit halfwords packed into one 32-bit word (first halfword in bits [31:16]). Each cycle it looks at the presented word and decides whether it is one of the four subroutine calls with an immediate offset: a wide call that stays in wide mode, a wide call that switches to compact mode, a compact call that stays in compact mode, and a compact call that switches to wide mode.

For a recognised call it assembles the scattered offset fields and sign-extends them. It then forms the return address that goes to the link register, computes the destination, and reports the mode the core runs in after the call. It also flags encodings that must trap as undefined, and compact calls that sit in a non-final slot of a predicated group. Condition evaluation and predicated-group tracking happen elsewhere. Their results arrive as plain inputs.

Every output is registered, so results appear one clock after the inputs are presented.

Top module: `call_imm_decoder`

## Requirements
- R1: With `cur_mode_i`=0 (wide), a word with bits [27:25]=101, bit 24=1 and bits [31:28]≠1111 is a call that stays wide. Its offset is bits [23:0] shifted left by 2 and sign-extended, giving a reach of -33554432 to 33554428. `tgt_mode_o`=0 and `target_o` = (PC with bits [1:0] cleared) + offset.
- R2: With `cur_mode_i`=0, a word with bits [31:28]=1111 and [27:25]=101 is a call that switches to compact mode. Bits [23:0] form offset bits [25:2], bit 24 forms offset bit 1, and bit 0 is 0, giving a reach of -33554432 to 33554430. `tgt_mode_o`=1 and `target_o` = PC + offset. The call is issued whatever the value of `cond_ok_i`.
- R3: The call of R1 is issued only when `cond_ok_i` is 1. When `cond_ok_i` is 0, `call_valid_o` stays 0.
- R4: With `cur_mode_i`=1 (compact), a word with bits [31:27]=11110, bits 15 and 14 = 1 and bit 12 = 1 is a call that stays compact. Let s=bit 26. Then k1 = NOT(bit 13 XOR s) and k2 = NOT(bit 11 XOR s). The offset is sign-extended {s,k1,k2,bits[25:16],bits[10:0],0}, with a reach of -16777216 to 16777214. `tgt_mode_o`=1 and `target_o` = PC + offset. `cond_ok_i` has no effect.
- R5: The same compact pattern with bit 12 = 0 is a call that switches to wide mode. Its offset is sign-extended {s,k1,k2,bits[25:16],bits[10:1],00}, with a reach of -16777216 to 16777212. `tgt_mode_o`=0 and `target_o` = (PC with bits [1:0] cleared) + offset.
- R6: In the form of R5, a word with bit 0 = 1 raises `undef_o`, keeps `call_valid_o` at 0 and does not raise `unpred_o`.
- R7: For either compact form, `in_grp_i`=1 with `grp_last_i`=0 raises `unpred_o` and keeps `call_valid_o` at 0. The group inputs have no effect on the wide forms, or when `grp_last_i`=1.
- R8: For an issued call, `link_o` is PC-4 when `cur_mode_i`=0, and PC with bit 0 set when `cur_mode_i`=1.
- R9: A word that matches none of the forms for the current mode gives `call_valid_o`, `undef_o` and `unpred_o` all 0. This covers a wide word with bit 24 = 0, and either mode's call word presented in the other mode.
- R10: Outputs appear on the clock edge after the inputs. A synchronous active-high `rst` clears `call_valid_o`, `undef_o` and `unpred_o`, and it has priority over a matching word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word (compact: first halfword in [31:16]) |
| cur_mode_i | input | 1 | Current instruction set: 0 wide, 1 compact |
| pc_i | input | PC_W | PC value as read by the executing instruction |
| cond_ok_i | input | 1 | Condition check passed |
| in_grp_i | input | 1 | Instruction is inside a predicated group |
| grp_last_i | input | 1 | Instruction is the last of its predicated group |
| call_valid_o | output | 1 | A call is issued |
| link_o | output | PC_W | Return address for the link register |
| target_o | output | PC_W | Call destination |
| tgt_mode_o | output | 1 | Instruction set after the call: 0 wide, 1 compact |
| undef_o | output | 1 | Undefined encoding |
| unpred_o | output | 1 | Compact call in a non-final group slot |

## Verification
Each of the four forms is encoded in the bench from a chosen offset, using the largest positive, the most negative and a zero offset. This separates wrong field order, a wrong inversion of the k bits and a wrong sign extension. Compact calls use a PC with bit 1 set, so only the wide-bound form shows the alignment step. Separate words then exercise the gating inputs: a low condition on the conditional wide form and on the unconditional forms, group slots on compact and wide words, and the undefined bit alone and together with a non-final slot. Near-miss words show that the decoder keys on mode and on the fixed bits.

// File: rtl/call_dec_pkg.sv
package call_dec_pkg;

   typedef enum logic {
      ISA_WIDE    = 1'b0,
      ISA_COMPACT = 1'b1
   } isa_e;

   typedef struct packed {
      logic hit;
      logic needs_cond;
      logic undef;
      logic unpred;
      isa_e tmode;
   } dec_res_t;

   localparam int WIDE_RAW_W    = 26;
   localparam int COMPACT_RAW_W = 25;

endpackage

// File: rtl/wide_call_dec.sv
module wide_call_dec
   import call_dec_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic [31:0]     insn_i,
   output dec_res_t        res_o,
   output logic [PC_W-1:0] off_o
);

   localparam int RAW_W = WIDE_RAW_W;

   if (PC_W < RAW_W) begin : g_bad_width
      $error("wide_call_dec: PC_W must be at least %0d", RAW_W);
   end

   logic             uncond;
   logic             frame_ok;
   logic [RAW_W-1:0] raw;

   always_comb begin
      uncond   = (insn_i[31:28] == 4'hF);
      frame_ok = (insn_i[27:25] == 3'b101) && (uncond || insn_i[24]);
      raw      = uncond ? {insn_i[23:0], insn_i[24], 1'b0}
                        : {insn_i[23:0], 2'b00};
      res_o            = '0;
      res_o.hit        = frame_ok;
      res_o.needs_cond = frame_ok && !uncond;
      res_o.tmode      = uncond ? ISA_COMPACT : ISA_WIDE;
   end

   if (PC_W == RAW_W) begin : g_same
      assign off_o = raw;
   end else begin : g_ext
      assign off_o = {{(PC_W-RAW_W){raw[RAW_W-1]}}, raw};
   end

endmodule

// File: rtl/compact_call_dec.sv
module compact_call_dec
   import call_dec_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic [31:0]     insn_i,
   input  logic            in_grp_i,
   input  logic            grp_last_i,
   output dec_res_t        res_o,
   output logic [PC_W-1:0] off_o
);

   localparam int RAW_W = COMPACT_RAW_W;

   if (PC_W < RAW_W) begin : g_bad_width
      $error("compact_call_dec: PC_W must be at least %0d", RAW_W);
   end

   logic             sgn, k1, k2;
   logic             frame_ok, xchg, bad_h;
   logic [RAW_W-1:0] raw;

   always_comb begin
      sgn      = insn_i[26];
      k1       = ~(insn_i[13] ^ sgn);
      k2       = ~(insn_i[11] ^ sgn);
      frame_ok = (insn_i[31:27] == 5'b11110) && (insn_i[15:14] == 2'b11);
      xchg     = ~insn_i[12];
      bad_h    = frame_ok && xchg && insn_i[0];
      raw      = xchg ? {sgn, k1, k2, insn_i[25:16], insn_i[10:1], 2'b00}
                      : {sgn, k1, k2, insn_i[25:16], insn_i[10:0], 1'b0};
      res_o            = '0;
      res_o.hit        = frame_ok;
      res_o.undef      = bad_h;
      res_o.unpred     = frame_ok && !bad_h && in_grp_i && !grp_last_i;
      res_o.tmode      = xchg ? ISA_WIDE : ISA_COMPACT;
   end

   if (PC_W == RAW_W) begin : g_same
      assign off_o = raw;
   end else begin : g_ext
      assign off_o = {{(PC_W-RAW_W){raw[RAW_W-1]}}, raw};
   end

endmodule

// File: rtl/call_addr_gen.sv
module call_addr_gen
   import call_dec_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic [PC_W-1:0] pc_i,
   input  isa_e            cur_mode_i,
   input  isa_e            tmode_i,
   input  logic [PC_W-1:0] off_i,
   output logic [PC_W-1:0] link_o,
   output logic [PC_W-1:0] target_o
);

   localparam logic [PC_W-1:0] LINK_BACK = PC_W'(4);

   logic [PC_W-1:0] base;

   always_comb begin
      link_o   = (cur_mode_i == ISA_WIDE) ? (pc_i - LINK_BACK)
                                          : {pc_i[PC_W-1:1], 1'b1};
      base     = (tmode_i == ISA_WIDE) ? {pc_i[PC_W-1:2], 2'b00} : pc_i;
      target_o = base + off_i;
   end

endmodule

// File: rtl/call_imm_decoder.sv
module call_imm_decoder
   import call_dec_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [31:0]     insn_i,
   input  logic            cur_mode_i,
   input  logic [PC_W-1:0] pc_i,
   input  logic            cond_ok_i,
   input  logic            in_grp_i,
   input  logic            grp_last_i,
   output logic            call_valid_o,
   output logic [PC_W-1:0] link_o,
   output logic [PC_W-1:0] target_o,
   output logic            tgt_mode_o,
   output logic            undef_o,
   output logic            unpred_o
);

   if (PC_W < WIDE_RAW_W) begin : g_bad_width
      $error("call_imm_decoder: PC_W must be at least %0d", WIDE_RAW_W);
   end

   dec_res_t        w_res, c_res, sel_res;
   logic [PC_W-1:0] w_off, c_off, sel_off;
   logic [PC_W-1:0] link_d, target_d;
   isa_e            cur_mode;
   logic            issue_d;

   assign cur_mode = isa_e'(cur_mode_i);

   wide_call_dec #(.PC_W(PC_W)) wide_dec_i (
      .insn_i (insn_i),
      .res_o  (w_res),
      .off_o  (w_off)
   );

   compact_call_dec #(.PC_W(PC_W)) compact_dec_i (
      .insn_i     (insn_i),
      .in_grp_i   (in_grp_i),
      .grp_last_i (grp_last_i),
      .res_o      (c_res),
      .off_o      (c_off)
   );

   always_comb begin
      sel_res = (cur_mode == ISA_WIDE) ? w_res : c_res;
      sel_off = (cur_mode == ISA_WIDE) ? w_off : c_off;
      issue_d = sel_res.hit && !sel_res.undef && !sel_res.unpred
                && (!sel_res.needs_cond || cond_ok_i);
   end

   call_addr_gen #(.PC_W(PC_W)) addr_gen_i (
      .pc_i       (pc_i),
      .cur_mode_i (cur_mode),
      .tmode_i    (sel_res.tmode),
      .off_i      (sel_off),
      .link_o     (link_d),
      .target_o   (target_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         call_valid_o <= 1'b0;
         undef_o      <= 1'b0;
         unpred_o     <= 1'b0;
      end else begin
         call_valid_o <= issue_d;
         undef_o      <= sel_res.undef;
         unpred_o     <= sel_res.unpred;
      end
   end

   always_ff @(posedge clk) begin
      link_o     <= link_d;
      target_o   <= target_d;
      tgt_mode_o <= sel_res.tmode;
   end

   AST_UNDEF_BLOCKS_CALL: assert property (@(posedge clk) disable iff (rst)
      undef_o |-> (!call_valid_o && !unpred_o)); // R6

   AST_WIDE_DEST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      (call_valid_o && !tgt_mode_o) |-> (target_o[1:0] == 2'b00)); // R5

   AST_COMPACT_LINK_ODD: assert property (@(posedge clk) disable iff (rst)
      (call_valid_o && $past(cur_mode_i)) |-> link_o[0]); // R8

   AST_COND_GATES_CALL: assert property (@(posedge clk) disable iff (rst)
      (call_valid_o && !$past(cur_mode_i) && ($past(insn_i[31:28]) != 4'hF))
      |-> $past(cond_ok_i)); // R3

   AST_UNPRED_FROM_SLOT: assert property (@(posedge clk) disable iff (rst)
      unpred_o |-> (!call_valid_o && $past(in_grp_i) && !$past(grp_last_i))); // R7

endmodule

// File: tb/call_imm_decoder_tb_top.sv
`timescale 1ns/1ps
module call_imm_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] insn = '0;
   logic        mode = 1'b0;
   logic [31:0] pc = '0;
   logic        cok = 1'b0;
   logic        ingrp = 1'b0;
   logic        lastg = 1'b0;
   logic        vld, tmo, und, unp;
   logic [31:0] lnk, tgt;

   int total = 0;
   int bad   = 0;

   typedef struct {
      logic        valid;
      logic        undef;
      logic        unpred;
      logic        tmode;
      logic [31:0] link;
      logic [31:0] target;
      string       tag;
   } exp_t;

   exp_t q[$];

   always #2 clk = ~clk;

   call_imm_decoder #(.PC_W(32)) dut_i (
      .clk(clk), .rst(rst), .insn_i(insn), .cur_mode_i(mode), .pc_i(pc),
      .cond_ok_i(cok), .in_grp_i(ingrp), .grp_last_i(lastg),
      .call_valid_o(vld), .link_o(lnk), .target_o(tgt), .tgt_mode_o(tmo),
      .undef_o(und), .unpred_o(unp)
   );

   // encoders built from the field layouts in the requirements
   function automatic logic [31:0] enc_wcall(input logic [3:0] c, input logic [31:0] o);
      return {c, 3'b101, 1'b1, o[25:2]};
   endfunction
   function automatic logic [31:0] enc_wswitch(input logic [31:0] o);
      return {4'hF, 3'b101, o[1], o[25:2]};
   endfunction
   function automatic logic [31:0] enc_ccall(input logic [31:0] o);
      logic s;
      s = o[24];
      return {5'b11110, s, o[21:12], 2'b11, ~o[23] ^ s, 1'b1, ~o[22] ^ s, o[11:1]};
   endfunction
   function automatic logic [31:0] enc_cswitch(input logic [31:0] o, input logic h);
      logic s;
      s = o[24];
      return {5'b11110, s, o[21:12], 2'b11, ~o[23] ^ s, 1'b0, ~o[22] ^ s, o[11:2], h};
   endfunction

   function automatic exp_t mk_call(input logic m, input logic tm, input logic [31:0] p,
                                    input logic [31:0] o, input string tag);
      exp_t e;
      e.valid  = 1'b1;
      e.undef  = 1'b0;
      e.unpred = 1'b0;
      e.tmode  = tm;
      e.link   = m ? (p | 32'd1) : (p - 32'd4);
      e.target = tm ? (p + o) : ((p & 32'hFFFF_FFFC) + o);
      e.tag    = tag;
      return e;
   endfunction
   function automatic exp_t mk_none(input logic u, input logic p, input string tag);
      exp_t e;
      e.valid  = 1'b0;
      e.undef  = u;
      e.unpred = p;
      e.tmode  = 1'b0;
      e.link   = '0;
      e.target = '0;
      e.tag    = tag;
      return e;
   endfunction

   task automatic drive(input logic [31:0] w, input logic m, input logic [31:0] p,
                        input logic c, input logic g, input logic l, input exp_t e);
      @(negedge clk);
      insn = w; mode = m; pc = p; cok = c; ingrp = g; lastg = l;
      q.push_back(e);
   endtask

   // monitor: compares one result per cycle after each posedge
   always @(posedge clk) begin : monitor
      exp_t e;
      #1;
      if (!rst && q.size() > 0) begin
         e = q.pop_front();
         total++;
         if (vld !== e.valid || und !== e.undef || unp !== e.unpred ||
             (e.valid && (lnk !== e.link || tgt !== e.target || tmo !== e.tmode))) begin
            bad++;
            $display("FAIL %s: got v=%b u=%b p=%b m=%b link=%h tgt=%h exp v=%b u=%b p=%b m=%b link=%h tgt=%h",
                     e.tag, vld, und, unp, tmo, lnk, tgt,
                     e.valid, e.undef, e.unpred, e.tmode, e.link, e.target);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: got timeout exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   localparam logic [31:0] PCW = 32'h0040_0008;
   localparam logic [31:0] PCC = 32'h0001_0006;

   initial begin : main
      logic [31:0] o;
      repeat (3) @(negedge clk);
      total++;  // R10 reset state
      if (vld !== 1'b0 || und !== 1'b0 || unp !== 1'b0) begin
         bad++;
         $display("FAIL R10 reset: got v=%b u=%b p=%b exp 0 0 0", vld, und, unp);
      end
      rst = 1'b0;

      // R1 wide call, three offsets, two conditions
      o = 32'd33554428;
      drive(enc_wcall(4'hE, o), 0, PCW, 1, 0, 0, mk_call(0, 0, PCW, o, "R1 max"));
      o = -32'sd33554432;
      drive(enc_wcall(4'h0, o), 0, PCW, 1, 0, 0, mk_call(0, 0, PCW, o, "R1 min"));
      o = 32'd0;
      drive(enc_wcall(4'hE, o), 0, PCW, 1, 0, 0, mk_call(0, 0, PCW, o, "R1 zero R8"));
      // R3 condition failed
      drive(enc_wcall(4'h1, 32'd64), 0, PCW, 0, 0, 0, mk_none(0, 0, "R3 cond low"));
      // R2 wide switch, three offsets, condition ignored
      o = 32'd33554430;
      drive(enc_wswitch(o), 0, PCW, 1, 0, 0, mk_call(0, 1, PCW, o, "R2 max"));
      o = -32'sd33554432;
      drive(enc_wswitch(o), 0, PCW, 0, 0, 0, mk_call(0, 1, PCW, o, "R2 min cond low"));
      o = 32'd0;
      drive(enc_wswitch(o), 0, PCW, 1, 0, 0, mk_call(0, 1, PCW, o, "R2 zero"));
      // R4 compact call
      o = 32'd16777214;
      drive(enc_ccall(o), 1, PCC, 1, 0, 0, mk_call(1, 1, PCC, o, "R4 max"));
      o = -32'sd16777216;
      drive(enc_ccall(o), 1, PCC, 0, 0, 0, mk_call(1, 1, PCC, o, "R4 min cond low"));
      o = 32'd0;
      drive(enc_ccall(o), 1, PCC, 1, 0, 0, mk_call(1, 1, PCC, o, "R4 zero R8"));
      // R5 compact switch to wide, aligned destination
      o = 32'd16777212;
      drive(enc_cswitch(o, 0), 1, PCC, 1, 0, 0, mk_call(1, 0, PCC, o, "R5 max"));
      o = -32'sd16777216;
      drive(enc_cswitch(o, 0), 1, PCC, 1, 0, 0, mk_call(1, 0, PCC, o, "R5 min"));
      o = 32'd0;
      drive(enc_cswitch(o, 0), 1, PCC, 1, 0, 0, mk_call(1, 0, PCC, o, "R5 zero"));
      // R6 undefined bit
      drive(enc_cswitch(32'd400, 1), 1, PCC, 1, 0, 0, mk_none(1, 0, "R6 h set"));
      drive(enc_cswitch(32'd400, 1), 1, PCC, 1, 1, 0, mk_none(1, 0, "R6 h set in slot"));
      // R7 predicated group slots
      drive(enc_ccall(32'd2), 1, PCC, 1, 1, 0, mk_none(0, 1, "R7 not last"));
      drive(enc_cswitch(32'd8, 0), 1, PCC, 1, 1, 0, mk_none(0, 1, "R7 switch not last"));
      drive(enc_ccall(32'd2), 1, PCC, 1, 1, 1, mk_call(1, 1, PCC, 32'd2, "R7 last"));
      drive(enc_wcall(4'hE, 32'd8), 0, PCW, 1, 1, 0, mk_call(0, 0, PCW, 32'd8, "R7 wide ignores"));
      // R9 near misses
      drive({4'hE, 3'b101, 1'b0, 24'h123456}, 0, PCW, 1, 0, 0, mk_none(0, 0, "R9 bit24 clear"));
      drive(enc_ccall(32'd2), 0, PCW, 1, 0, 0, mk_none(0, 0, "R9 compact word wide"));
      drive(enc_wcall(4'hE, 32'd8), 1, PCC, 1, 0, 0, mk_none(0, 0, "R9 wide word compact"));
      drive(enc_cswitch(32'd8, 0) & ~32'h0000_4000, 1, PCC, 1, 0, 0, mk_none(0, 0, "R9 bit14 clear"));
      repeat (3) @(negedge clk);

      // R10 reset beats a matching word
      rst = 1'b1;
      insn = enc_wcall(4'hE, 32'd8); mode = 0; pc = PCW; cok = 1; ingrp = 0;
      @(posedge clk);
      #1;
      total++;
      if (vld !== 1'b0) begin
         bad++;
         $display("FAIL R10 reset priority: got v=%b exp 0", vld);
      end
      @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule